// File: doc/BRIEF.md
# Addressable LED Frame Sequencer

This block tracks where a refresh frame for a chain of serially addressed RGB LEDs currently stands, one clock at a time. It emits a tagged position command every cycle. The command is either a latch (return) period, or an LED command that names the LED being sent, the bit of that LED's 24-bit colour word, and how many cycles of that bit's slot have already elapsed. A downstream colour lookup and a line waveform shaper use this command to drive the data pin. Neither of those is part of this block.

The chain length and the two timing constants are inputs, given in clock cycles, so the same logic can be retuned for any clock rate. At 100 MHz a bit slot is 125 cycles and the latch period is 28000 cycles. Within each LED, bits are sent from most significant to least significant. After the last LED the sequencer holds the latch period and then starts the next frame again at the first LED. Reset places the sequencer at the start of a latch period, so the chain latches cleanly before any data is sent.

Top module: `led_frame_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is the return variant (`cmd_is_led` = 0) with `cmd_dur` = 0. This holds also when reset arrives in the middle of a frame.
- R2: The return variant lasts `ret_cycles` cycles, and `cmd_dur` counts 0, 1, … , `ret_cycles`-1 during it.
- R3: The cycle after the return period ends shows the LED variant (`cmd_is_led` = 1) with LED index 0, bit index 23 and `cmd_dur` = 0.
- R4: In the LED variant, `cmd_dur` counts 0 … `slot_cycles`-1. After reaching `slot_cycles`-1 it returns to 0 and the bit index drops by one (23 down to 0, most significant bit first).
- R5: After the last cycle of bit 0 of LED k, where k < `num_leds`-1, the next cycle shows LED k+1, bit 23, `cmd_dur` 0.
- R6: After the last cycle of bit 0 of LED `num_leds`-1, the next cycle is the return variant with `cmd_dur` = 0. The frame period is therefore `ret_cycles` + `num_leds`·24·`slot_cycles` cycles.
- R7: In the return variant, `cmd_led` and `cmd_bit` read 0.
- R8: With `num_leds` = 0 the sequencer stays in the return variant. Its `cmd_dur` restarts at 0 every `ret_cycles` cycles.
- R9: A `slot_cycles` or `ret_cycles` value of 0 behaves as 1.
- R10: In the LED variant, `cmd_led` is always below `num_leds`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| num_leds | input | IDX_W | Number of LEDs in the chain |
| slot_cycles | input | CNT_W | Cycles per data bit slot |
| ret_cycles | input | CNT_W | Cycles in the latch/return period |
| cmd_is_led | output | 1 | 1 = LED variant, 0 = return variant |
| cmd_led | output | IDX_W | LED index (0 in return variant) |
| cmd_bit | output | BIT_W | Bit index in the colour word, 23..0 (0 in return variant) |
| cmd_dur | output | CNT_W | Elapsed cycles in the current slot or return period |

## Verification
All four outputs come from registers that update together. The command visible after the k-th rising edge following reset release therefore corresponds to frame position k, with no further latency. The bench changes `rst` and the configuration only on falling edges. It then counts exactly k rising edges and samples on the following falling edge. Expected positions come from a closed-form model: the frame position is k modulo the frame period, split into return cycles, LED, bit and slot cycle. This model checks the hand-worked table rows, a full frame at 100 MHz timing, and a cycle-by-cycle sweep.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
  typedef enum logic {
    PH_RET = 1'b0,
    PH_LED = 1'b1
  } phase_e;
endpackage

// File: rtl/seq_slot_timer.sv
module seq_slot_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] dur,
  output logic             last
);
  logic [CNT_W:0] dur_inc;

  // a limit of 0 ends the slot after one cycle, same as 1
  assign dur_inc = {1'b0, dur} + 1'b1;
  assign last    = dur_inc >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst)       dur <= '0;
    else if (last) dur <= '0;
    else           dur <= dur_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/seq_bit_walker.sv
module seq_bit_walker #(
  parameter int BITS  = 24,
  parameter int BIT_W = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [BIT_W-1:0] bit_idx,
  output logic             at_zero
);
  localparam logic [BIT_W-1:0] TOP = BIT_W'(BITS - 1);

  assign at_zero = (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (rst)          bit_idx <= TOP;
    else if (step) begin
      if (at_zero)    bit_idx <= TOP;
      else            bit_idx <= bit_idx - 1'b1;
    end
  end
endmodule

// File: rtl/seq_led_walker.sv
module seq_led_walker #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [IDX_W-1:0] num_leds,
  output logic [IDX_W-1:0] led_idx,
  output logic             at_last
);
  logic [IDX_W:0] led_inc;

  assign led_inc = {1'b0, led_idx} + 1'b1;
  assign at_last = led_inc >= {1'b0, num_leds};

  always_ff @(posedge clk) begin
    if (rst)          led_idx <= '0;
    else if (step) begin
      if (at_last)    led_idx <= '0;
      else            led_idx <= led_inc[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq
  import led_seq_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 16,
  parameter int BITS_PER_LED = 24,
  parameter int BIT_W = $clog2(BITS_PER_LED)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] num_leds,
  input  logic [CNT_W-1:0] slot_cycles,
  input  logic [CNT_W-1:0] ret_cycles,
  output logic             cmd_is_led,
  output logic [IDX_W-1:0] cmd_led,
  output logic [BIT_W-1:0] cmd_bit,
  output logic [CNT_W-1:0] cmd_dur
);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(BITS_PER_LED - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] limit;
  logic             slot_last;
  logic             bit_step, bit_zero;
  logic             led_step, led_last;
  logic [BIT_W-1:0] bit_q;
  logic [IDX_W-1:0] led_q;
  logic             frame_end;

  assign limit     = (phase_q == PH_LED) ? slot_cycles : ret_cycles;
  assign bit_step  = (phase_q == PH_LED) && slot_last;
  assign led_step  = bit_step && bit_zero;
  assign frame_end = led_step && led_last;

  seq_slot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .limit(limit), .dur(cmd_dur), .last(slot_last)
  );

  seq_bit_walker #(.BITS(BITS_PER_LED), .BIT_W(BIT_W)) u_bits (
    .clk(clk), .rst(rst), .step(bit_step), .bit_idx(bit_q), .at_zero(bit_zero)
  );

  seq_led_walker #(.IDX_W(IDX_W)) u_leds (
    .clk(clk), .rst(rst), .step(led_step), .num_leds(num_leds),
    .led_idx(led_q), .at_last(led_last)
  );

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_RET;
    else begin
      case (phase_q)
        PH_RET:  if (slot_last && (num_leds != '0)) phase_q <= PH_LED;
        PH_LED:  if (frame_end) phase_q <= PH_RET;
        default: phase_q <= PH_RET;
      endcase
    end
  end

  assign cmd_is_led = (phase_q == PH_LED);
  assign cmd_led    = cmd_is_led ? led_q : '0;
  assign cmd_bit    = cmd_is_led ? bit_q : '0;

  // R1: reset lands at the start of a return period
  a_r1_reset_ret: assert property (@(posedge clk)
    rst |=> (!cmd_is_led && cmd_dur == '0));

  // R3: every frame begins at LED 0, top bit
  a_r3_frame_start: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_is_led) |-> (cmd_led == '0 && cmd_bit == BIT_TOP && cmd_dur == '0));

  // R4: slot counter advances by one inside a slot
  a_r4_dur_step: assert property (@(posedge clk) disable iff (rst)
    (cmd_is_led && $past(cmd_is_led) && cmd_dur != '0) |-> (cmd_dur == $past(cmd_dur) + 1'b1));

  // R5: LED index advances after bit 0 of a non-final LED
  a_r5_led_advance: assert property (@(posedge clk) disable iff (rst)
    (bit_step && bit_zero && !led_last) |=>
      (cmd_is_led && cmd_led == $past(cmd_led) + 1'b1 && cmd_bit == BIT_TOP));

  // R6: final LED's bit 0 leads into the return period
  a_r6_frame_end: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (!cmd_is_led && cmd_dur == '0));

  // R10: the index stays inside the chain
  a_r10_led_in_range: assert property (@(posedge clk) disable iff (rst)
    cmd_is_led |-> ({1'b0, cmd_led} < {1'b0, num_leds}));
endmodule

// File: tb/tb_led_frame_seq.sv
`timescale 1ns/1ps
module tb_led_frame_seq;
  localparam int IDX_W = 8;
  localparam int CNT_W = 16;
  localparam int BIT_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [IDX_W-1:0] num_leds = '0;
  logic [CNT_W-1:0] slot_cycles = '0;
  logic [CNT_W-1:0] ret_cycles = '0;
  logic             cmd_is_led;
  logic [IDX_W-1:0] cmd_led;
  logic [BIT_W-1:0] cmd_bit;
  logic [CNT_W-1:0] cmd_dur;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  led_frame_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .num_leds(num_leds), .slot_cycles(slot_cycles),
    .ret_cycles(ret_cycles), .cmd_is_led(cmd_is_led), .cmd_led(cmd_led),
    .cmd_bit(cmd_bit), .cmd_dur(cmd_dur)
  );

  typedef struct packed {
    logic [31:0] num, slot, ret, n, is_led, led, bitn, dur, req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{4, 5, 10,   0, 0, 0,  0, 0, 1},  // R1 reset state
    '{4, 5, 10,   9, 0, 0,  0, 9, 2},  // R2 last return cycle
    '{4, 5, 10,  10, 1, 0, 23, 0, 3},  // R3 first LED cycle
    '{4, 5, 10,  14, 1, 0, 23, 4, 4},  // R4 end of slot
    '{4, 5, 10,  15, 1, 0, 22, 0, 4},  // R4 next bit
    '{4, 5, 10, 129, 1, 0,  0, 4, 4},  // R4 last bit of LED 0
    '{4, 5, 10, 130, 1, 1, 23, 0, 5},  // R5 LED 1 starts
    '{4, 5, 10, 489, 1, 3,  0, 4, 6},  // R6 last cycle of frame
    '{4, 5, 10, 490, 0, 0,  0, 0, 6},  // R6 back to return
    '{4, 5, 10, 500, 1, 0, 23, 0, 3},  // R3 second frame
    '{1, 3,  2,   1, 0, 0,  0, 1, 2},  // R2 short return
    '{1, 3,  2,   2, 1, 0, 23, 0, 3},  // R3
    '{1, 3,  2,  73, 1, 0,  0, 2, 6},  // R6 single LED
    '{1, 3,  2,  74, 0, 0,  0, 0, 6},  // R6
    '{2, 1,  1,   1, 1, 0, 23, 0, 3},  // R3 one-cycle slots
    '{2, 1,  1,  24, 1, 0,  0, 0, 4},  // R4
    '{2, 1,  1,  25, 1, 1, 23, 0, 5},  // R5
    '{2, 1,  1,  49, 0, 0,  0, 0, 6}   // R6
  };

  task automatic check(input string req, input int e_led_v, input int e_led,
                       input int e_bit, input int e_dur);
    checks++;
    if (int'(cmd_is_led) != e_led_v || int'(cmd_led) != e_led ||
        int'(cmd_bit) != e_bit || int'(cmd_dur) != e_dur) begin
      fails++;
      $display("FAIL %s: got is_led=%0d led=%0d bit=%0d dur=%0d, expected is_led=%0d led=%0d bit=%0d dur=%0d",
               req, cmd_is_led, cmd_led, cmd_bit, cmd_dur, e_led_v, e_led, e_bit, e_dur);
    end
  endtask

  task automatic do_reset(input int num, input int slot, input int ret);
    @(negedge clk);
    rst = 1'b1;
    num_leds = IDX_W'(num);
    slot_cycles = CNT_W'(slot);
    ret_cycles = CNT_W'(ret);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  // closed-form frame position after n edges since reset release
  task automatic model(input int num, input int slot, input int ret, input int n,
                       output int is_led, output int led, output int bitn, output int dur);
    int s, r, p, m, j;
    s = (slot < 1) ? 1 : slot;
    r = (ret < 1) ? 1 : ret;
    is_led = 0; led = 0; bitn = 0;
    if (num == 0) begin
      dur = n % r;
    end else begin
      p = r + num * 24 * s;
      m = n % p;
      if (m < r) dur = m;
      else begin
        j = m - r;
        is_led = 1;
        led = j / (24 * s);
        bitn = 23 - ((j / s) % 24);
        dur = j % s;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    int e_v, e_l, e_b, e_d;
    // table walk
    for (int i = 0; i < NV; i++) begin
      do_reset(int'(TBL[i].num), int'(TBL[i].slot), int'(TBL[i].ret));
      step(int'(TBL[i].n));
      check($sformatf("R%0d row %0d", TBL[i].req, i), int'(TBL[i].is_led),
            int'(TBL[i].led), int'(TBL[i].bitn), int'(TBL[i].dur));
    end

    // R1 and R7: reset in the middle of a frame
    do_reset(4, 5, 10);
    step(200);
    check("R4 mid-frame position", 1, 1, 9, 0);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    check("R1_R7 mid-frame reset", 0, 0, 0, 0);

    // R8: empty chain stays in return
    do_reset(0, 5, 4);
    step(3);
    check("R8 empty chain dur 3", 0, 0, 0, 3);
    step(1);
    check("R8 empty chain wraps", 0, 0, 0, 0);
    step(50);
    check("R8 empty chain long run", 0, 0, 0, 2);

    // R9: zero timing values act as one
    do_reset(1, 0, 0);
    check("R9 zero timing reset", 0, 0, 0, 0);
    step(1);
    check("R9 zero return length", 1, 0, 23, 0);
    step(1);
    check("R9 zero slot length", 1, 0, 22, 0);
    step(23);
    check("R9 frame end", 0, 0, 0, 0);

    // R2..R6 at 100 MHz timing
    do_reset(4, 125, 28000);
    step(27999);
    check("R2 full return end", 0, 0, 0, 27999);
    step(1);
    check("R3 full frame start", 1, 0, 23, 0);
    step(124);
    check("R4 full slot end", 1, 0, 23, 124);
    step(1);
    check("R4 full next bit", 1, 0, 22, 0);
    step(40000 - 28125);
    check("R6 full frame wraps", 0, 0, 0, 0);

    // R10 and all: cycle-by-cycle sweep
    do_reset(3, 4, 6);
    for (int n = 0; n < 600; n++) begin
      model(3, 4, 6, n, e_v, e_l, e_b, e_d);
      check($sformatf("R10 sweep n=%0d", n), e_v, e_l, e_b, e_d);
      step(1);
    end

    finish_run();
  end
endmodule